// File: doc/BRIEF.md
# Ordered Variable-Length Codeword Packer

Several encoding cores run side by side, one per spectral band of a pixel. Each core emits one codeword per cycle, and each codeword has its own bit length. This block takes one such group of up to `LANES` codewords in a cycle. It joins them into one continuous bitstream with no gaps, lowest lane first. Lane order matches the band order in which the samples arrived. Where a codeword lands depends on the summed lengths of every earlier codeword. The block therefore computes a prefix sum of the lane lengths to build a left-aligned group vector. It then appends that vector behind the bits already waiting in an accumulator.

The stream leaves as 32-bit words, first bit in bit 31, on a valid/ready handshake. A group enters on `in_valid` and `in_ready`. Both are sampled at a rising edge, and a group offered while `in_ready` is low is not taken. `in_ready` depends only on registered state, never on `out_ready`. It drops when the accumulator has less free space than one worst-case group (`LANES*MAXLEN` bits). Back-pressure from the output side therefore reaches the cores only through buffer occupancy. Once `out_valid` rises it stays high, with the word held steady, until `out_ready` takes the word.

An end-of-image pulse on `eoi` flushes the stream. Full words drain first, and any remaining bits then go out in one last word padded with zeros. New groups are refused until the accumulator is empty, so the next image starts on a word boundary.

Top module: `cw_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted group adds the codewords of its valid lanes in lane order, lane 0 first. Each codeword goes in from its bit `len-1` down to bit 0. It is placed right after the last bit of the previous group, with no gap.
- R3: Two kinds of input add no bits to the stream: a lane whose valid flag is 0, and a lane whose length is 0. Code bits at or above the lane's length are ignored. A lane's length field is `LW` bits wide and ranges from 0 to `MAXLEN`.
- R4: Output words are 32 bits wide. The earliest pending stream bit is in `out_data[31]`, and a word is offered as soon as 32 bits are pending.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change in the next cycle.
- R6: `in_ready` is 0 whenever the accumulator holds more than `BUF_W - LANES*MAXLEN` bits. A group presented while `in_ready` is 0 is ignored and adds nothing to the stream.
- R7: After an `eoi` pulse, all pending bits are emitted. A final partial word carries its bits from bit 31 downward and is zero below them. If no bits are pending, no word is produced. `in_ready` is 0 from the cycle after the pulse until the accumulator is empty.
- R8: Across any run of groups and flushes, each codeword bit appears in the output exactly once, in order. Bits of a group accepted after a flush start a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A codeword group is presented |
| in_ready | output | 1 | The group will be accepted at this edge |
| lane_vld | input | LANES | Per-lane codeword present flag |
| lane_len | input | LANES*LW | Per-lane bit length, lane i at [i*LW +: LW] |
| lane_code | input | LANES*MAXLEN | Per-lane codeword, right-aligned, lane i at [i*MAXLEN +: MAXLEN] |
| eoi | input | 1 | End-of-image pulse, requests a flush |
| out_valid | output | 1 | An output word is offered |
| out_ready | input | 1 | Sink takes the offered word |
| out_data | output | 32 | Output word, earliest bit in bit 31 |

## Verification
Two situations are hard to reach from the ports. The first is a refused group. A group is refused only when the accumulator sits above the threshold, so the stimulus holds `out_ready` low and loads one full-length group. It then offers junk groups during the stall and checks that the stream never shows them. The second is the case where a partial word is stuck behind a stalled sink while a flush is pending. Random sink stalls run together with random `eoi` pulses so that flushes land on odd bit counts. An `eoi` on an empty accumulator checks that no spurious word appears.

// File: rtl/cw_packer_pkg.sv
package cw_packer_pkg;
  localparam int unsigned WORD_W = 32;

  function automatic int unsigned len_bits(input int unsigned maxlen);
    return $clog2(maxlen + 1);
  endfunction
endpackage

// File: rtl/cw_offsets.sv
module cw_offsets #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned MAXLEN = 16,
  parameter int unsigned LW     = 5,
  parameter int unsigned TW     = 7
) (
  input  logic [LANES-1:0]    lane_vld,
  input  logic [LANES*LW-1:0] lane_len,
  output logic [LANES*TW-1:0] lane_off,
  output logic [TW-1:0]       total_len
);
  logic [TW-1:0] run [0:LANES];

  assign run[0] = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_prefix
    logic [TW-1:0] eff;
    assign eff = lane_vld[i] ? TW'(lane_len[i*LW +: LW]) : '0;
    assign run[i+1] = run[i] + eff;
    assign lane_off[i*TW +: TW] = run[i];
  end

  assign total_len = run[LANES];
endmodule

// File: rtl/cw_merge.sv
module cw_merge #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned MAXLEN = 16,
  parameter int unsigned LW     = 5,
  parameter int unsigned TW     = 7,
  localparam int unsigned GW    = LANES * MAXLEN
) (
  input  logic [LANES-1:0]        lane_vld,
  input  logic [LANES*LW-1:0]     lane_len,
  input  logic [LANES*MAXLEN-1:0] lane_code,
  input  logic [LANES*TW-1:0]     lane_off,
  output logic [GW-1:0]           grp
);
  always_comb begin
    grp = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [MAXLEN-1:0]    la;
      logic [GW+MAXLEN-1:0] wide;
      la   = lane_code[i*MAXLEN +: MAXLEN] << (LW'(MAXLEN) - lane_len[i*LW +: LW]);
      wide = {la, {GW{1'b0}}} >> lane_off[i*TW +: TW];
      if (lane_vld[i]) grp = grp | wide[GW+MAXLEN-1 -: GW];
    end
  end
endmodule

// File: rtl/cw_accum.sv
module cw_accum #(
  parameter int unsigned GW    = 64,
  parameter int unsigned TW    = 7,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned BUF_W = GW + OUT_W,
  localparam int unsigned CW   = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [GW-1:0]    grp,
  input  logic [TW-1:0]    glen,
  input  logic             eoi,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             room,
  output logic             flushing
);
  logic [BUF_W-1:0] acc, acc_p, acc_n;
  logic [CW-1:0]    cnt, cnt_p, cnt_n;
  logic             pend, pend_n;
  logic             full_word, pop;

  assign full_word = cnt >= CW'(OUT_W);
  assign out_valid = full_word || (pend && cnt != '0);
  assign out_data  = acc[BUF_W-1 -: OUT_W];
  assign room      = cnt <= CW'(BUF_W - GW);
  assign flushing  = pend;
  assign pop       = out_valid && out_ready;

  always_comb begin
    acc_p = acc;
    cnt_p = cnt;
    if (pop) begin
      if (full_word) begin
        acc_p = acc << OUT_W;
        cnt_p = cnt - CW'(OUT_W);
      end else begin
        acc_p = '0;
        cnt_p = '0;
      end
    end
    acc_n = acc_p;
    cnt_n = cnt_p;
    if (push) begin
      acc_n = acc_p | ({grp, {(BUF_W-GW){1'b0}}} >> cnt_p);
      cnt_n = cnt_p + CW'(glen);
    end
    pend_n = pend;
    if (eoi) pend_n = 1'b1;
    else if (pend && cnt_n == '0) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      acc  <= acc_n;
      cnt  <= cnt_n;
      pend <= pend_n;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BUF_W));

  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend && pop && !full_word && !push |=> cnt == '0);

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !full_word |-> (out_data << cnt) == '0);
endmodule

// File: rtl/cw_packer.sv
module cw_packer
  import cw_packer_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned MAXLEN = 16,
  localparam int unsigned LW    = $clog2(MAXLEN + 1),
  localparam int unsigned GW    = LANES * MAXLEN,
  localparam int unsigned TW    = $clog2(GW + 1),
  localparam int unsigned BUF_W = GW + WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        lane_vld,
  input  logic [LANES*LW-1:0]     lane_len,
  input  logic [LANES*MAXLEN-1:0] lane_code,
  input  logic                    eoi,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data
);
  logic [LANES*TW-1:0] lane_off;
  logic [TW-1:0]       total_len;
  logic [GW-1:0]       grp;
  logic                room, flushing, push;

  cw_offsets #(.LANES(LANES), .MAXLEN(MAXLEN), .LW(LW), .TW(TW)) offs_i (
    .lane_vld (lane_vld),
    .lane_len (lane_len),
    .lane_off (lane_off),
    .total_len(total_len)
  );

  cw_merge #(.LANES(LANES), .MAXLEN(MAXLEN), .LW(LW), .TW(TW)) merge_i (
    .lane_vld (lane_vld),
    .lane_len (lane_len),
    .lane_code(lane_code),
    .lane_off (lane_off),
    .grp      (grp)
  );

  assign in_ready = room && !flushing;
  assign push     = in_valid && in_ready;

  cw_accum #(.GW(GW), .TW(TW), .OUT_W(WORD_W), .BUF_W(BUF_W)) accum_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .grp      (grp),
    .glen     (total_len),
    .eoi      (eoi),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .room     (room),
    .flushing (flushing)
  );

  p_total_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> total_len <= TW'(GW));
endmodule

// File: tb/cw_packer_tb_top.sv
module cw_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int MAXLEN = 16;
  localparam int LW     = $clog2(MAXLEN + 1);
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0]        lane_vld  = '0;
  logic [LANES*LW-1:0]     lane_len  = '0;
  logic [LANES*MAXLEN-1:0] lane_code = '0;
  logic eoi = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mon_en = 0;
  bit rdy_rand = 0;
  bit rdy_force = 1;
  string cur_req = "R2";
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_packer #(.LANES(LANES), .MAXLEN(MAXLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lane_vld(lane_vld), .lane_len(lane_len), .lane_code(lane_code),
    .eoi(eoi), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // sink ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rdy_rand) out_ready = ($urandom % 4) != 0;
      else out_ready = rdy_force;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R5", {out_valid, out_data}, {1'b1, prev_data});
        if (out_valid && out_ready) begin
          if (exp_q.size() < 32) begin
            check(0, {cur_req, " R8 extra word"}, out_data, exp_q.size());
          end else begin
            logic [31:0] w;
            for (int b = 31; b >= 0; b--) w[b] = exp_q.pop_front();
            check(out_data == w, {cur_req, " R4"}, out_data, w);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R8 actual=%0d expected=0", exp_q.size());
    finish_run();
  end

  task automatic send(input logic [LANES-1:0] v, input logic [LANES*LW-1:0] l,
                      input logic [LANES*MAXLEN-1:0] c);
    @(posedge clk); #1;
    lane_vld = v; lane_len = l; lane_code = c; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < LANES; i++)
      if (v[i])
        for (int b = int'(l[i*LW +: LW]) - 1; b >= 0; b--)
          exp_q.push_back(c[i*MAXLEN + b]);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_rand();
    logic [LANES-1:0] v;
    logic [LANES*LW-1:0] l;
    logic [LANES*MAXLEN-1:0] c;
    v = LANES'($urandom);
    for (int i = 0; i < LANES; i++) begin
      l[i*LW +: LW] = LW'($urandom % (MAXLEN + 1));
      c[i*MAXLEN +: MAXLEN] = MAXLEN'($urandom);
    end
    send(v, l, c);
  endtask

  task automatic pulse_eoi();
    @(posedge clk); #1;
    eoi = 1'b1;
    while ((exp_q.size() % 32) != 0) exp_q.push_back(1'b0);
    @(posedge clk); #1;
    eoi = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    @(negedge clk);
    while ((exp_q.size() != 0 || !in_ready) && n < 2000) begin
      @(negedge clk); n++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  function automatic logic [LANES*LW-1:0] lens4(int a, int b, int c, int d);
    return {LW'(d), LW'(c), LW'(b), LW'(a)};
  endfunction

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", {out_valid, in_ready}, 2'b01);
    mon_en = 1;

    // R2: full lanes, mixed lengths, back to back
    cur_req = "R2";
    send(4'b1111, lens4(16, 1, 7, 3), 64'h0005_007F_0001_ABCD);
    send(4'b1111, lens4(9, 16, 2, 12), 64'h0A5A_0003_F00F_01C3);
    send(4'b1111, lens4(5, 5, 5, 5), 64'h0011_000A_0015_001F);
    send(4'b1111, lens4(16, 16, 16, 16), 64'h1234_5678_9ABC_DEF0);

    // R3: invalid lanes, zero lengths, junk high code bits
    cur_req = "R3";
    send(4'b0101, lens4(6, 16, 4, 16), 64'hFFFF_FFFF_FFFF_FFFF);
    send(4'b1111, lens4(0, 3, 0, 8), 64'hFFAA_FFFF_FFF2_FFFF);
    send(4'b0000, lens4(16, 16, 16, 16), 64'hDEAD_BEEF_DEAD_BEEF);
    send(4'b1000, lens4(1, 1, 1, 11), 64'hF8C3_0000_0000_0000);
    cur_req = "R7";
    pulse_eoi();
    drain("R7 first flush");

    // R6: fill while sink stalled, refused groups ignored
    cur_req = "R6";
    rdy_force = 0;
    @(posedge clk);
    send(4'b1111, lens4(16, 16, 16, 16), 64'hCAFE_F00D_0BAD_1DEA);
    @(negedge clk);
    check(in_ready == 1'b0, "R6 ready low above threshold", in_ready, 0);
    @(posedge clk); #1;
    lane_vld = 4'hF; lane_len = lens4(16, 16, 16, 16); lane_code = 64'hFFFF_0000_FFFF_0000;
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R6 ready low while stalled", in_ready, 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    rdy_force = 1;
    drain("R6 no refused bits");

    // R7: partial flush, ready low during flush
    cur_req = "R7";
    send(4'b0011, lens4(3, 2, 0, 0), 64'h0000_0000_0002_0005);
    @(posedge clk); #1;
    eoi = 1'b1;
    while ((exp_q.size() % 32) != 0) exp_q.push_back(1'b0);
    rdy_force = 0;
    @(posedge clk); #1;
    eoi = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R7 ready low during flush", in_ready, 0);
    check(out_valid == 1'b1, "R7 partial word offered", out_valid, 1);
    rdy_force = 1;
    drain("R7 partial flush");
    // eoi with nothing pending: no word
    pulse_eoi();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 empty flush no word", out_valid, 0);
    check(in_ready == 1'b1, "R7 ready back after empty flush", in_ready, 1);

    // R8: new image starts at word boundary, then random traffic
    cur_req = "R8";
    send(4'b0011, lens4(16, 16, 0, 0), 64'h0000_0000_89AB_4567);
    drain("R8 aligned word");
    rdy_rand = 1;
    for (int g = 0; g < 400; g++) begin
      send_rand();
      if (($urandom % 25) == 0) pulse_eoi();
    end
    pulse_eoi();
    rdy_rand = 0;
    rdy_force = 1;
    drain("R8 final drain");
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 idle at end", out_valid, 0);
    finish_run();
  end
endmodule